// File: doc/BRIEF.md
# Costas Carrier Recovery Loop

This block strips the leftover carrier frequency and phase from complex baseband samples in an M-PSK receiver. It expects one sample per symbol, after timing recovery has resampled the stream. Each incoming I/Q pair is rotated backwards by the angle held in a local numerically controlled oscillator (NCO). A decision-directed detector compares the rotated sample with the nearest ideal constellation point and produces a phase error. A second-order loop filter turns that error into a phase increment for the NCO.

The constellation size can be changed at run time between two, four and eight phases. The proportional and integral loop gains are given as right-shift amounts. The block outputs the rotated sample together with the raw phase error, so that an external lock monitor can watch how the loop converges. Once the loop has locked, the rotated stream is the demodulated baseband signal.

Top module: `costas_loop`

## Requirements
- R1: A synchronous active-low reset clears the phase accumulator, the integrator, the output sample, the phase error and `out_valid`.
- R2: `out_valid` is high in the cycle after a cycle with `in_valid` high, and low otherwise. While `in_valid` is low, the outputs, the integrator and the phase accumulator hold their values.
- R3: Let k be the top 10 bits (31:22) of the 32-bit phase accumulator, S = round(32767·sin(2πk/1024)) and C = round(32767·sin(2π(k+256)/1024)). Then `out_i` = sat16((I·C + Q·S + 2^14) >>> 15) and `out_q` = sat16((Q·C − I·S + 2^14) >>> 15). Here sat16 clamps to the range −32768..32767.
- R4: With `mod_sel` = 0 (two phases), the error is Q' when I' ≥ 0 and −Q' otherwise. I' and Q' are the rotated outputs of the same sample.
- R5: With `mod_sel` = 1 (four phases), the error is Q'·s(I') − I'·s(Q'), where s(x) = +1 for x ≥ 0 and −1 otherwise.
- R6: With `mod_sel` = 2 or 3 (eight phases), let a = |I'|, b = |Q'|, mx = max(a,b) and mn = min(a,b). When 128·mn < 53·mx and a ≥ b, the error is Q'·s(I'). When 128·mn < 53·mx and a < b, the error is −I'·s(Q'). In all other cases the error is ((Q'·s(I') − I'·s(Q'))·181) >>> 8.
- R7: On each valid sample, let e = error·2^14. The integrator becomes integ + (e >>> `ki_shift`). The accumulator then grows by (e >>> `kp_shift`) plus the new integrator value. Both values wrap modulo 2^32, and the new accumulator value applies to the next sample.
- R8: Two-phase symbols are fed in at a constant 30° offset, with `kp_shift` = 2 and `ki_shift` = 31. After 300 symbols, |`phase_err`| is below 500.
- R9: A valid sample with I = Q = 0 produces a phase error of 0 in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input sample qualifier |
| in_i | input | 16 | Input in-phase sample, signed |
| in_q | input | 16 | Input quadrature sample, signed |
| mod_sel | input | 2 | 0: two phases, 1: four phases, 2/3: eight phases |
| kp_shift | input | 5 | Proportional gain as a right shift |
| ki_shift | input | 5 | Integral gain as a right shift |
| out_valid | output | 1 | Output qualifier |
| out_i | output | 16 | Rotated in-phase sample, signed |
| out_q | output | 16 | Rotated quadrature sample, signed |
| phase_err | output | 18 | Raw detector error, signed |

## Verification
The assertions assume that `in_valid` is always a known level and marks exactly the cycles that carry a sample. They also assume that the mode and gains held during a valid cycle are the ones that determine that sample's error. Under these assumptions, the two-phase error stays within ±32768 and the four-phase error within ±65536. The stimulus changes `mod_sel` and the shift amounts only between runs. It inserts invalid cycles carrying garbage data, so the hold behaviour is exercised. It keeps full-scale corner samples inside the signed 16-bit range, so the detector bounds stay reachable but are never exceeded.

// File: rtl/costas_pkg.sv
// Shared definitions for the carrier recovery loop.
// Assumes a 2-bit modulation selector; code 3 is treated as eight phases.
package costas_pkg;
    typedef enum logic [1:0] {
        MOD_TWO   = 2'd0,
        MOD_FOUR  = 2'd1,
        MOD_EIGHT = 2'd2,
        MOD_EIGHT_ALT = 2'd3
    } mod_e;
endpackage

// File: rtl/costas_nco.sv
// Phase accumulator plus sine/cosine lookup.
// Assumes LUT_BITS <= ACC_W and a table computed once at start of time.
module costas_nco #(
    parameter int ACC_W    = 32,
    parameter int LUT_BITS = 10,
    parameter int DATA_W   = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     adv,
    input  logic [ACC_W-1:0]         step,
    output logic signed [DATA_W-1:0] sin_o,
    output logic signed [DATA_W-1:0] cos_o
);
    localparam int  DEPTH   = 1 << LUT_BITS;
    localparam int  QUARTER = DEPTH / 4;
    localparam real AMP     = real'((1 << (DATA_W - 1)) - 1);
    localparam real TWO_PI  = 6.283185307179586;

    logic signed [DATA_W-1:0] wave_tab [DEPTH];
    logic [ACC_W-1:0]         acc;
    logic [LUT_BITS-1:0]      sin_addr;
    logic [LUT_BITS-1:0]      cos_addr;

    // Fill the sine table with rounded samples of one full period.
    initial begin
        for (int k = 0; k < DEPTH; k++) begin
            real v;
            v = AMP * $sin(TWO_PI * real'(k) / real'(DEPTH));
            wave_tab[k] = DATA_W'($rtoi(v >= 0.0 ? v + 0.5 : v - 0.5));
        end
    end

    // Address the table from the accumulator top bits; cosine leads by a quarter turn.
    always_comb begin
        sin_addr = acc[ACC_W-1 -: LUT_BITS];
        cos_addr = sin_addr + LUT_BITS'(QUARTER);
        sin_o    = wave_tab[sin_addr];
        cos_o    = wave_tab[cos_addr];
    end

    // Advance the phase once per accepted sample.
    always_ff @(posedge clk) begin
        if (!rst_n)   acc <= '0;
        else if (adv) acc <= acc + step;
    end

    // R2
    acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(acc));
endmodule

// File: rtl/costas_mixer.sv
// Complex derotation of one sample by the NCO angle, rounded and saturated.
// Assumes sine/cosine amplitude of 2^(DATA_W-1)-1.
module costas_mixer #(
    parameter int DATA_W = 16
) (
    input  logic signed [DATA_W-1:0] in_i,
    input  logic signed [DATA_W-1:0] in_q,
    input  logic signed [DATA_W-1:0] sin_v,
    input  logic signed [DATA_W-1:0] cos_v,
    output logic signed [DATA_W-1:0] mix_i,
    output logic signed [DATA_W-1:0] mix_q
);
    localparam int SUM_W = 2 * DATA_W + 1;
    localparam int RND   = 1 << (DATA_W - 2);
    localparam logic signed [SUM_W-1:0] MAXV = SUM_W'((1 << (DATA_W - 1)) - 1);
    localparam logic signed [SUM_W-1:0] MINV = -SUM_W'(1 << (DATA_W - 1));

    logic signed [SUM_W-1:0] sum_i, sum_q, rnd_i, rnd_q;

    function automatic logic signed [DATA_W-1:0] clamp(input logic signed [SUM_W-1:0] v);
        if (v > MAXV)      return MAXV[DATA_W-1:0];
        else if (v < MINV) return MINV[DATA_W-1:0];
        else               return v[DATA_W-1:0];
    endfunction

    // Multiply by the conjugate phasor, round half up, then clamp.
    always_comb begin
        sum_i = SUM_W'(in_i) * SUM_W'(cos_v) + SUM_W'(in_q) * SUM_W'(sin_v);
        sum_q = SUM_W'(in_q) * SUM_W'(cos_v) - SUM_W'(in_i) * SUM_W'(sin_v);
        rnd_i = (sum_i + SUM_W'(RND)) >>> (DATA_W - 1);
        rnd_q = (sum_q + SUM_W'(RND)) >>> (DATA_W - 1);
        mix_i = clamp(rnd_i);
        mix_q = clamp(rnd_q);
    end
endmodule

// File: rtl/costas_ped.sv
// Decision-directed phase detector for two, four or eight phases.
// Assumes ERR_W = DATA_W + 2 so the four-phase sum cannot overflow.
module costas_ped
    import costas_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ERR_W  = DATA_W + 2
) (
    input  logic signed [DATA_W-1:0] ri,
    input  logic signed [DATA_W-1:0] rq,
    input  logic [1:0]               mode,
    output logic signed [ERR_W-1:0]  err
);
    localparam int CMP_W   = ERR_W + 7;
    localparam int PROD_W  = ERR_W + 9;
    localparam int TAN_NUM = 53;
    localparam int TAN_SH  = 7;
    localparam int DIAG_NUM = 181;
    localparam int DIAG_SH  = 8;

    logic signed [ERR_W-1:0]  i_x, q_x, qsx, isy, quad, mag_i, mag_q, mx, mn;
    logic signed [ERR_W-1:0]  axis_e, eight_e;
    logic [CMP_W-1:0]         lhs, rhs;
    logic signed [PROD_W-1:0] dprod, dshift;
    logic                     pos_i, pos_q;
    mod_e                     m;

    // Fold signs, pick the nearest ideal point and form the error per mode.
    always_comb begin
        m      = mod_e'(mode);
        i_x    = ERR_W'(ri);
        q_x    = ERR_W'(rq);
        pos_i  = !ri[DATA_W-1];
        pos_q  = !rq[DATA_W-1];
        qsx    = pos_i ? q_x : -q_x;
        isy    = pos_q ? i_x : -i_x;
        quad   = qsx - isy;
        mag_i  = pos_i ? i_x : -i_x;
        mag_q  = pos_q ? q_x : -q_x;
        mx     = (mag_i >= mag_q) ? mag_i : mag_q;
        mn     = (mag_i >= mag_q) ? mag_q : mag_i;
        lhs    = CMP_W'($unsigned(mn)) << TAN_SH;
        rhs    = CMP_W'($unsigned(mx)) * CMP_W'(TAN_NUM);
        axis_e = (mag_i >= mag_q) ? qsx : -isy;
        dprod  = PROD_W'(quad) * PROD_W'(DIAG_NUM);
        dshift = dprod >>> DIAG_SH;
        eight_e = (lhs < rhs) ? axis_e : dshift[ERR_W-1:0];
        case (m)
            MOD_TWO:  err = qsx;
            MOD_FOUR: err = quad;
            default:  err = eight_e;
        endcase
    end
endmodule

// File: rtl/costas_loop_filter.sv
// Proportional-plus-integral loop filter producing the NCO phase step.
// Assumes ACC_W >= ERR_W; the error is aligned to the accumulator top bits.
module costas_loop_filter #(
    parameter int ACC_W   = 32,
    parameter int ERR_W   = 18,
    parameter int SHIFT_W = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    adv,
    input  logic signed [ERR_W-1:0] err,
    input  logic [SHIFT_W-1:0]      kp_shift,
    input  logic [SHIFT_W-1:0]      ki_shift,
    output logic [ACC_W-1:0]        step
);
    localparam int ALIGN = ACC_W - ERR_W;

    logic signed [ACC_W-1:0] e_ext, integ, integ_n;

    // Scale the error and form the new integrator and step.
    always_comb begin
        e_ext   = {err, {ALIGN{1'b0}}};
        integ_n = integ + (e_ext >>> ki_shift);
        step    = ACC_W'((e_ext >>> kp_shift) + integ_n);
    end

    // Integrate only on accepted samples.
    always_ff @(posedge clk) begin
        if (!rst_n)   integ <= '0;
        else if (adv) integ <= integ_n;
    end

    // R2
    integ_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(integ));
endmodule

// File: rtl/costas_loop.sv
// Top of the carrier recovery loop: NCO, mixer, detector, loop filter, output register.
// Assumes one sample per symbol and gains held steady while samples flow.
module costas_loop
    import costas_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int ACC_W    = 32,
    parameter int LUT_BITS = 10,
    parameter int SHIFT_W  = 5,
    parameter int ERR_W    = DATA_W + 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] in_i,
    input  logic signed [DATA_W-1:0] in_q,
    input  logic [1:0]               mod_sel,
    input  logic [SHIFT_W-1:0]       kp_shift,
    input  logic [SHIFT_W-1:0]       ki_shift,
    output logic                     out_valid,
    output logic signed [DATA_W-1:0] out_i,
    output logic signed [DATA_W-1:0] out_q,
    output logic signed [ERR_W-1:0]  phase_err
);
    localparam int LIM_TWO  = 1 << (DATA_W - 1);
    localparam int LIM_FOUR = 1 << DATA_W;

    logic signed [DATA_W-1:0] sin_v, cos_v, mix_i, mix_q;
    logic signed [ERR_W-1:0]  err;
    logic [ACC_W-1:0]         step;

    costas_nco #(.ACC_W(ACC_W), .LUT_BITS(LUT_BITS), .DATA_W(DATA_W)) u_nco (
        .clk(clk), .rst_n(rst_n), .adv(in_valid), .step(step),
        .sin_o(sin_v), .cos_o(cos_v)
    );

    costas_mixer #(.DATA_W(DATA_W)) u_mix (
        .in_i(in_i), .in_q(in_q), .sin_v(sin_v), .cos_v(cos_v),
        .mix_i(mix_i), .mix_q(mix_q)
    );

    costas_ped #(.DATA_W(DATA_W), .ERR_W(ERR_W)) u_ped (
        .ri(mix_i), .rq(mix_q), .mode(mod_sel), .err(err)
    );

    costas_loop_filter #(.ACC_W(ACC_W), .ERR_W(ERR_W), .SHIFT_W(SHIFT_W)) u_lf (
        .clk(clk), .rst_n(rst_n), .adv(in_valid), .err(err),
        .kp_shift(kp_shift), .ki_shift(ki_shift), .step(step)
    );

    // Register the rotated sample and its error when a sample arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_i     <= '0;
            out_q     <= '0;
            phase_err <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_i     <= mix_i;
                out_q     <= mix_q;
                phase_err <= err;
            end
        end
    end

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R2
    valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R2
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_i) && $stable(out_q) && $stable(phase_err)));
    // R9
    zero_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_i == '0 && in_q == '0) |=> phase_err == '0);
    // R4
    two_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mod_sel == MOD_TWO) |=>
        (int'(phase_err) <= LIM_TWO && int'(phase_err) >= -LIM_TWO));
    // R5
    four_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mod_sel == MOD_FOUR) |=>
        (int'(phase_err) <= LIM_FOUR && int'(phase_err) >= -LIM_FOUR));
endmodule

// File: tb/costas_loop_test.sv
`timescale 1ns/1ps
module costas_loop_test;
    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               in_valid = 1'b0;
    logic signed [15:0] in_i = '0;
    logic signed [15:0] in_q = '0;
    logic [1:0]         mod_sel = '0;
    logic [4:0]         kp_shift = 5'd3;
    logic [4:0]         ki_shift = 5'd12;
    logic               out_valid;
    logic signed [15:0] out_i, out_q;
    logic signed [17:0] phase_err;

    int checks = 0;
    int errors = 0;
    bit chk_en = 1'b0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    costas_loop uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
        .mod_sel(mod_sel), .kp_shift(kp_shift), .ki_shift(ki_shift),
        .out_valid(out_valid), .out_i(out_i), .out_q(out_q), .phase_err(phase_err)
    );

    // Behavioural reference state
    int    tab [1024];
    int    m_acc, m_integ, m_oi, m_oq, m_err;
    bit    m_vld;
    string m_tag = "R1";
    string d_tag = "R1";

    function automatic int sat16(longint v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return int'(v);
    endfunction

    function automatic int sgn(int v);
        return (v >= 0) ? 1 : -1;
    endfunction

    function automatic int ped(int ri, int rq, int mode);
        int a, b, mx, mn;
        a = (ri >= 0) ? ri : -ri;
        b = (rq >= 0) ? rq : -rq;
        mx = (a >= b) ? a : b;
        mn = (a >= b) ? b : a;
        if (mode == 0) return rq * sgn(ri);
        if (mode == 1) return rq * sgn(ri) - ri * sgn(rq);
        if (128 * mn < 53 * mx) return (a >= b) ? rq * sgn(ri) : -ri * sgn(rq);
        return ((rq * sgn(ri) - ri * sgn(rq)) * 181) >>> 8;
    endfunction

    initial begin
        for (int k = 0; k < 1024; k++) begin
            real v;
            v = 32767.0 * $sin(6.283185307179586 * real'(k) / 1024.0);
            tab[k] = $rtoi(v >= 0.0 ? v + 0.5 : v - 0.5);
        end
    end

    // Reference model, advanced on every rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_acc = 0; m_integ = 0; m_oi = 0; m_oq = 0; m_err = 0; m_vld = 0;
            m_tag = "R1"; d_tag = "R1";
        end else if (in_valid) begin
            int k, c, s, ii, qq, e;
            ii = in_i; qq = in_q;
            k = (m_acc >>> 22) & 1023;
            s = tab[k];
            c = tab[(k + 256) % 1024];
            m_oi = sat16((longint'(ii) * c + longint'(qq) * s + 16384) >>> 15);
            m_oq = sat16((longint'(qq) * c - longint'(ii) * s + 16384) >>> 15);
            m_err = ped(m_oi, m_oq, int'(mod_sel));
            e = m_err * 16384;
            m_integ = m_integ + (e >>> ki_shift);
            m_acc = m_acc + ((e >>> kp_shift) + m_integ);
            m_vld = 1;
            m_tag = (mod_sel == 2'd0) ? "R4" : (mod_sel == 2'd1) ? "R5" : "R6";
            d_tag = "R3 R7";
        end else begin
            m_vld = 0;
            m_tag = "R2"; d_tag = "R2";
        end
    end

    task automatic check(string tag, string what, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s got %0d expected %0d", tag, what, got, exp);
        end
    endtask

    // Compare against the model on every falling edge
    always @(negedge clk) begin
        if (chk_en) begin
            check("R2", "out_valid", int'(out_valid), int'(m_vld));
            check(d_tag, "out_i", int'(out_i), m_oi);
            check(d_tag, "out_q", int'(out_q), m_oq);
            check(m_tag, "phase_err", int'(phase_err), m_err);
        end
    end

    task automatic send(bit v, int i, int q);
        in_valid = v;
        in_i = 16'(i);
        in_q = 16'(q);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        send(0, 0, 0);
        send(0, 0, 0);
        rst_n = 1'b1;
    endtask

    // Symbol stream on an M-point constellation with offset and drift
    task automatic run_psk(int mode, int nsym, real off, real df, bit gaps);
        int  m;
        real base;
        m = (mode == 0) ? 2 : (mode == 1) ? 4 : 8;
        base = (mode == 1) ? 0.785398163 : 0.0;
        mod_sel = 2'(mode);
        for (int n = 0; n < nsym; n++) begin
            int  sym;
            real ang;
            if (gaps && (n % 5 == 4))
                send(0, int'($urandom_range(65535)) - 32768, int'($urandom_range(65535)) - 32768);
            sym = int'($urandom_range(m - 1));
            ang = base + off + df * real'(n) + 6.283185307179586 * real'(sym) / real'(m);
            send(1, $rtoi(20000.0 * $cos(ang)), $rtoi(20000.0 * $sin(ang)));
        end
    endtask

    initial begin
        #1_000_000;
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R1: state after reset
        checks++; if (out_valid !== 1'b0) begin errors++; $display("FAIL R1 out_valid got %0d expected 0", out_valid); end
        checks++; if (out_i !== 16'sd0 || out_q !== 16'sd0) begin errors++; $display("FAIL R1 out_i/out_q got %0d/%0d expected 0/0", out_i, out_q); end
        checks++; if (phase_err !== 18'sd0) begin errors++; $display("FAIL R1 phase_err got %0d expected 0", phase_err); end
        chk_en = 1'b1;

        kp_shift = 5'd3; ki_shift = 5'd12;
        run_psk(0, 300, 0.4, 0.002, 1);       // R4 with gaps (R2)
        kp_shift = 5'd4; ki_shift = 5'd10;
        run_psk(1, 300, -0.2, -0.003, 1);     // R5
        kp_shift = 5'd5; ki_shift = 5'd11;
        run_psk(2, 300, 0.1, 0.001, 0);       // R6
        run_psk(3, 200, 0.3, 0.0, 1);         // R6 alternate code

        // R3: full-scale corners in all modes to reach saturation
        kp_shift = 5'd1; ki_shift = 5'd6;
        for (int n = 0; n < 400; n++) begin
            int ci, cq;
            mod_sel = 2'(n % 4);
            ci = ($urandom_range(1) == 1) ? 32767 : -32768;
            cq = ($urandom_range(1) == 1) ? 32767 : -32768;
            send(1, ci, cq);
        end

        // R9: zero input in every mode
        for (int md = 0; md < 4; md++) begin
            mod_sel = 2'(md);
            send(1, 0, 0);
            @(posedge clk); #1;
            checks++;
            if (phase_err !== 18'sd0) begin errors++; $display("FAIL R9 phase_err got %0d expected 0", phase_err); end
            @(negedge clk);
        end

        // R1: reset in the middle of traffic
        chk_en = 1'b0;
        do_reset();
        checks++; if (out_valid !== 1'b0 || out_i !== 16'sd0 || phase_err !== 18'sd0) begin
            errors++; $display("FAIL R1 mid reset got valid %0d i %0d err %0d expected 0 0 0", out_valid, out_i, phase_err);
        end
        chk_en = 1'b1;

        // R8: convergence from a constant 30 degree offset
        kp_shift = 5'd2; ki_shift = 5'd31; mod_sel = 2'd0;
        for (int n = 0; n < 300; n++) begin
            int s;
            s = ($urandom_range(1) == 1) ? 1 : -1;
            send(1, s * 13856, s * 8000);
        end
        send(0, 0, 0);
        checks++;
        if (int'(phase_err) >= 500 || int'(phase_err) <= -500) begin
            errors++; $display("FAIL R8 |phase_err| got %0d expected below 500", phase_err);
        end

        send(0, 0, 0);
        chk_en = 1'b0;
        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule